// File: doc/BRIEF.md
# Transmit Gearbox Sequence Controller

This block drives a transmit gearbox that takes its sequence count from outside. It keeps a sequence counter and presents the count, a sync header and a data word to the gearbox. It also pauses the upstream word source at fixed counts, which gives the gearbox the time it needs to absorb the extra header bits. Two framings are supported: 64-bit payload with a 2-bit header (66-bit frames) and 64-bit payload with a 3-bit header (67-bit frames). The interface to the gearbox is either 2 bytes or 4 bytes wide.

The upstream source offers a word on `inData`, together with the header for that word on `inHdr` and a `inValid` flag. A word is taken on each cycle in which `upReady` is high. The count, header and data outputs are registered and stay aligned with each other, one cycle behind the slot in which the word was taken. The mode and width selects are sampled only while reset is held.

Top module: `gbx_seq_top`

## Requirements
- R1: While `rst` is high, `upReady`, `seqOut`, `hdrOut` and `dataOut` are all zero. After reset is released and before the first valid word arrives, `seqOut` stays at 0 and `upReady` is high for as long as the source stays idle.
- R2: The first word offered with `inValid` high while `upReady` is high is sequence count 0. On the following cycle it appears on `dataOut` with `seqOut` equal to 0 and its header on `hdrOut`.
- R3: With the 4-byte interface (`narrowSel`=0), once transmission has started, `seqOut` advances by one every clock cycle.
- R4: With the 2-byte interface (`narrowSel`=1), each count value lasts two cycles and a word is taken in each of them. Only the low half of `inData` is passed on, and the upper half of `dataOut` is zero.
- R5: The count runs from 0 to 66 in 67-bit mode (`mode67`=1) and from 0 to 32 in 66-bit mode (`mode67`=0), then wraps to 0.
- R6: In 67-bit mode, `upReady` is low exactly during the slots whose count is 21, 44 or 65. Each such pause lasts one cycle with the 4-byte interface and two cycles with the 2-byte interface.
- R7: In 66-bit mode, `upReady` is low exactly during the slots whose count is 31.
- R8: During a pause, the word on `inData` is ignored and `dataOut` keeps its previous value. Words leave the block in the order they were taken, with none dropped and none repeated.
- R9: A header is captured on the first cycle of every second non-pause count, with data-count index k = count minus the number of pause counts below it, and a header taken when k is even. This counting restarts at the wrap. Between captures `hdrOut` holds its value. In 66-bit mode `hdrOut[2]` is 0.
- R10: Once transmission has started, the count keeps running when `inValid` is low. In that case a non-pause slot puts zero on `dataOut`, and a header slot puts zero on `hdrOut`.
- R11: A change of `mode67` or `narrowSel` while `rst` is low has no effect. The wrap point, the pause positions and the interface width stay as they were sampled during reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | User clock |
| rst | input | 1 | Synchronous reset, active high; the mode selects are sampled while it is held |
| mode67 | input | 1 | 1 selects 67-bit framing, 0 selects 66-bit framing |
| narrowSel | input | 1 | 1 selects the 2-byte interface, 0 selects the 4-byte interface |
| inValid | input | 1 | Upstream word valid |
| inData | input | DATA_W | Upstream data word |
| inHdr | input | 3 | Header for the block that starts with this word |
| upReady | output | 1 | High when the current slot takes a word; low during pauses and reset |
| seqOut | output | 7 | Sequence count to the gearbox |
| hdrOut | output | 3 | Sync header to the gearbox |
| dataOut | output | DATA_W | Data word to the gearbox |

## Verification
The bench sweeps all four combinations of framing and interface width. In each one it streams numbered words for more than two full counter periods, so every pause position and both wraps are visited in both widths. Comparing each output word and header against the word index tells apart a skipped or repeated word, a pause placed one count off, and a header parity that fails to restart at the wrap. A burst with the source idle in the middle of the stream separates zero fill from a stalled counter. Toggling the selects partway through shows that the latched configuration still sets the wrap and the pause positions.

// File: rtl/gbx_seq_pkg.sv
package gbx_seq_pkg;
  localparam int SEQ_W = 7;
  localparam int HDR_W = 3;
  localparam int LAST_67 = 66;
  localparam int LAST_66 = 32;
  localparam int PAUSE_67_A = 21;
  localparam int PAUSE_67_B = 44;
  localparam int PAUSE_67_C = 65;
  localparam int PAUSE_66 = 31;

  typedef struct packed {
    logic loadData;
    logic loadHdr;
    logic fillZero;
    logic narrow;
    logic shortHdr;
  } dpStrb_t;
endpackage

// File: rtl/gbx_seq_ctrl.sv
module gbx_seq_ctrl
  import gbx_seq_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             mode67,
  input  logic             narrowSel,
  input  logic             inValid,
  output logic             upReady,
  output logic [SEQ_W-1:0] seqOut,
  output dpStrb_t          strb
);
  logic [SEQ_W-1:0] cnt, lastCnt;
  logic phase, hdrPh, startedQ, mode67Q, narrowQ;
  logic isPause, pauseNow, slotGo, countDone;

  always_comb begin
    lastCnt = mode67Q ? SEQ_W'(LAST_67) : SEQ_W'(LAST_66);
    if (mode67Q)
      isPause = (cnt == SEQ_W'(PAUSE_67_A)) || (cnt == SEQ_W'(PAUSE_67_B)) ||
                (cnt == SEQ_W'(PAUSE_67_C));
    else
      isPause = (cnt == SEQ_W'(PAUSE_66));
    pauseNow  = startedQ & isPause;
    upReady   = ~rst & ~pauseNow;
    slotGo    = ~rst & (startedQ | inValid);
    countDone = ~narrowQ | phase;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt      <= '0;
      phase    <= 1'b0;
      hdrPh    <= 1'b0;
      startedQ <= 1'b0;
      seqOut   <= '0;
      mode67Q  <= mode67;
      narrowQ  <= narrowSel;
    end else if (slotGo) begin
      startedQ <= 1'b1;
      seqOut   <= cnt;
      phase    <= narrowQ & ~phase;
      if (countDone) begin
        if (cnt == lastCnt) begin
          cnt   <= '0;
          hdrPh <= 1'b0;
        end else begin
          cnt <= cnt + 1'b1;
          if (!isPause) hdrPh <= ~hdrPh;
        end
      end
    end
  end

  always_comb begin
    strb.loadData = slotGo & ~pauseNow;
    strb.loadHdr  = slotGo & ~pauseNow & ~hdrPh & ~phase;
    strb.fillZero = ~inValid;
    strb.narrow   = narrowQ;
    strb.shortHdr = ~mode67Q;
  end

  // R3: with the 4-byte interface the count steps by one each cycle
  a_r3_step: assert property (@(posedge clk) disable iff (rst)
    (startedQ && $past(startedQ) && !narrowQ && seqOut != lastCnt)
      |=> seqOut == $past(seqOut) + 1'b1);

  // R5: the count never passes the wrap point of the latched mode
  a_r5_range: assert property (@(posedge clk) disable iff (rst)
    seqOut <= lastCnt);

  // R6 / R7: a stalled slot is always reported at a pause count
  a_r6_pause_seq: assert property (@(posedge clk) disable iff (rst)
    !upReady |=> (mode67Q ? (seqOut == SEQ_W'(PAUSE_67_A) || seqOut == SEQ_W'(PAUSE_67_B) ||
                             seqOut == SEQ_W'(PAUSE_67_C))
                          : (seqOut == SEQ_W'(PAUSE_66))));
endmodule

// File: rtl/gbx_seq_dpath.sv
module gbx_seq_dpath
  import gbx_seq_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  dpStrb_t           strb,
  input  logic [DATA_W-1:0] inData,
  input  logic [HDR_W-1:0]  inHdr,
  output logic [DATA_W-1:0] dataOut,
  output logic [HDR_W-1:0]  hdrOut
);
  localparam int HALF = DATA_W / 2;
  localparam int SHORT_HDR_W = HDR_W - 1;

  logic [DATA_W-1:0] wordSel;
  logic [HDR_W-1:0]  hdrSel;

  always_comb begin
    if (strb.fillZero)     wordSel = '0;
    else if (strb.narrow)  wordSel = {{(DATA_W-HALF){1'b0}}, inData[HALF-1:0]};
    else                   wordSel = inData;
    if (strb.fillZero)     hdrSel = '0;
    else if (strb.shortHdr) hdrSel = {1'b0, inHdr[SHORT_HDR_W-1:0]};
    else                   hdrSel = inHdr;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      dataOut <= '0;
      hdrOut  <= '0;
    end else begin
      if (strb.loadData) dataOut <= wordSel;
      if (strb.loadHdr)  hdrOut  <= hdrSel;
    end
  end

  // R8: the data register holds whenever the control withholds a load
  a_r8_hold: assert property (@(posedge clk) disable iff (rst)
    !strb.loadData |=> $stable(dataOut));

  // R4: the 2-byte interface never sets the upper half of the word
  a_r4_upper_zero: assert property (@(posedge clk) disable iff (rst)
    strb.narrow |-> dataOut[DATA_W-1:HALF] == '0);

  // R9: the short header leaves its top bit clear
  a_r9_short_hdr: assert property (@(posedge clk) disable iff (rst)
    strb.shortHdr |-> !hdrOut[HDR_W-1]);
endmodule

// File: rtl/gbx_seq_top.sv
module gbx_seq_top
  import gbx_seq_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              mode67,
  input  logic              narrowSel,
  input  logic              inValid,
  input  logic [DATA_W-1:0] inData,
  input  logic [HDR_W-1:0]  inHdr,
  output logic              upReady,
  output logic [SEQ_W-1:0]  seqOut,
  output logic [HDR_W-1:0]  hdrOut,
  output logic [DATA_W-1:0] dataOut
);
  dpStrb_t strb;

  gbx_seq_ctrl u_ctrl (
    .clk       (clk),
    .rst       (rst),
    .mode67    (mode67),
    .narrowSel (narrowSel),
    .inValid   (inValid),
    .upReady   (upReady),
    .seqOut    (seqOut),
    .strb      (strb)
  );

  gbx_seq_dpath #(.DATA_W(DATA_W)) u_dpath (
    .clk     (clk),
    .rst     (rst),
    .strb    (strb),
    .inData  (inData),
    .inHdr   (inHdr),
    .dataOut (dataOut),
    .hdrOut  (hdrOut)
  );
endmodule

// File: tb/tb_gbx_seq_top.sv
module tb_gbx_seq_top;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic mode67 = 1'b0, narrowSel = 1'b0, inValid = 1'b0;
  logic [31:0] inData = '0;
  logic [2:0]  inHdr = '0;
  logic        upReady;
  logic [6:0]  seqOut;
  logic [2:0]  hdrOut;
  logic [31:0] dataOut;
  int total = 0, bad = 0;

  always #2 clk = ~clk;

  gbx_seq_top dut (
    .clk(clk), .rst(rst), .mode67(mode67), .narrowSel(narrowSel),
    .inValid(inValid), .inData(inData), .inHdr(inHdr),
    .upReady(upReady), .seqOut(seqOut), .hdrOut(hdrOut), .dataOut(dataOut)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%h exp=%h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [31:0] wordOf(int w);
    return {16'hC0DE ^ 16'(w * 7), 16'(w)};
  endfunction

  function automatic logic [2:0] hdrOf(int w);
    return 3'(w * 3 + 1);
  endfunction

  function automatic bit isPauseCnt(bit m, int c);
    return m ? (c == 21 || c == 44 || c == 65) : (c == 31);
  endfunction

  function automatic int pausesBelow(bit m, int c);
    return m ? int'(c > 21) + int'(c > 44) + int'(c > 65) : int'(c > 31);
  endfunction

  task automatic runConfig(input bit m, input bit nw, input int nCycles);
    int w = 0;
    int period = m ? 67 : 33;
    logic [31:0] expData = '0;
    logic [2:0]  expHdr = '0;
    rst = 1'b1; inValid = 1'b0; mode67 = m; narrowSel = nw;
    repeat (3) @(negedge clk);
    // R1: everything zero while reset is held
    chk(upReady == 1'b0, "R1 ready in reset", 32'(upReady), 0);
    chk(seqOut == 0, "R1 seq in reset", 32'(seqOut), 0);
    chk(dataOut == 0, "R1 data in reset", dataOut, 0);
    chk(hdrOut == 0, "R1 hdr in reset", 32'(hdrOut), 0);
    rst = 1'b0;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      chk(seqOut == 0, "R1 idle seq", 32'(seqOut), 0);
      chk(upReady == 1'b1, "R1 idle ready", 32'(upReady), 1);
    end
    for (int n = 0; n < nCycles; n++) begin
      int slot = nw ? n / 2 : n;
      int cnt = slot % period;
      bit ph = nw ? bit'(n % 2) : 1'b0;
      bit pz = isPauseCnt(m, cnt);
      bit drop = (n >= 150 && n < 154);
      int k = cnt - pausesBelow(m, cnt);
      bit hSlot = !pz && (k % 2 == 0) && !ph;
      string rtag;
      rtag = m ? "R6 ready" : "R7 ready";
      chk(upReady == !pz, rtag, 32'(upReady), 32'(!pz));
      inValid = !drop;
      inData = pz ? 32'hDEAD_BEEF : wordOf(w);
      inHdr = pz ? 3'b111 : hdrOf(w);
      // R11: flip the selects while running
      if (n == 40) begin mode67 = ~m; narrowSel = ~nw; end
      @(negedge clk);
      if (n > 40 && cnt == 0) rtag = "R11 seq after select change";
      else if (n > 0 && cnt == 0) rtag = "R5 seq wrap";
      else rtag = nw ? "R4 seq" : "R3 seq";
      chk(seqOut == 7'(cnt), rtag, 32'(seqOut), 32'(cnt));
      if (!pz) begin
        if (drop) expData = '0;
        else expData = nw ? {16'h0, wordOf(w)[15:0]} : wordOf(w);
      end
      if (hSlot) begin
        if (drop) expHdr = '0;
        else expHdr = m ? hdrOf(w) : (hdrOf(w) & 3'b011);
      end
      if (n == 0) rtag = "R2 first word";
      else if (pz) rtag = "R8 pause hold";
      else if (drop) rtag = "R10 zero fill";
      else rtag = "R8 data order";
      chk(dataOut == expData, rtag, dataOut, expData);
      rtag = drop ? "R10 hdr" : "R9 hdr";
      chk(hdrOut == expHdr, rtag, 32'(hdrOut), 32'(expHdr));
      if (!pz && !drop) w++;
    end
    inValid = 1'b0;
  endtask

  initial begin
    runConfig(1'b1, 1'b0, 300);
    runConfig(1'b1, 1'b1, 300);
    runConfig(1'b0, 1'b0, 300);
    runConfig(1'b0, 1'b1, 300);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule